// File: doc/BRIEF.md
# Dual-Bank Flash Status Register

This block keeps one 8-bit status word for each of the two banks of a flash array. Each word shows whether that bank's embedded program/erase engine is idle, whether an operation is suspended, and which failures have been seen since software last cleared them. The engine and the command decoder raise single-cycle event pulses per bank. The decoder also raises a per-bank clear pulse when it accepts the clear-status command. The engine's busy level is an input and is not stored.

Reads are made through a request/response pair. A request carries a word address, and the block decodes that address to one of the two banks. Bank "a" is the small region at one end of the address space, and a parameter chooses which end. The word is captured into a response register when the request is accepted. It stays in that register until the consumer takes it, so later engine activity cannot change the value being read. The response is 16 bits wide, with the status in the low byte.

Back-pressure works as follows. A request transfers on a cycle where `rd_valid` and `rd_ready` are both high. `rd_ready` is high when the response register is empty, or when it is being emptied in that same cycle. A response transfers on a cycle where `rsp_valid` and `rsp_ready` are both high. While `rsp_ready` is low, the response holds both its valid flag and its data.

Top module: `dual_bank_status`

## Requirements
- R1: After reset, with both engines idle, a read of either bank returns 0x0080, and no response is pending.
- R2: The fields are: bit 7 ready, bit 6 erase suspended, bit 5 erase failure, bit 4 program failure, bit 3 supply-voltage failure, bit 2 program suspended, bit 1 locked-block failure, bit 0 always 0. Bit 7 is 0 while that bank's engine is busy and not suspended, and 1 otherwise.
- R3: A failure pulse sets its bit (program to bit 4, erase to bit 5, supply to bit 3, locked block to bit 1). The bit stays set across any later activity until that bank is cleared.
- R4: An invalid-sequence pulse sets both bit 4 and bit 5 of its bank in the same cycle.
- R5: A clear pulse for a bank zeroes bits 1, 3, 4 and 5 of that bank only. It leaves the suspend bits and the other bank unchanged.
- R6: When a failure pulse and a clear pulse reach the same bank in the same cycle, the failure bit ends up set.
- R7: A program-suspend pulse sets bit 2 and an erase-suspend pulse sets bit 6. While either bit is set, bit 7 reads 1 even if the engine is busy. A resume pulse clears both bits.
- R8: With top placement, addresses from 2^ADDR_W − BANK_A_WORDS up to the top select bank a (index 0), and all others select bank b (index 1). With bottom placement, addresses below BANK_A_WORDS select bank a.
- R9: The upper byte of every response is 0x00.
- R10: A response carries the selected bank's status as it was in the cycle the request was accepted. The value stays unchanged until the response is taken.
- R11: `rd_ready` is low while a response is held under back-pressure. `rsp_valid` falls after the response is taken if no new request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_busy | input | 2 | Per-bank engine busy level |
| ev_prog_fail | input | 2 | Per-bank program failure pulse |
| ev_erase_fail | input | 2 | Per-bank erase failure pulse |
| ev_vpp_low | input | 2 | Per-bank supply-voltage failure pulse |
| ev_lock_hit | input | 2 | Per-bank locked-block failure pulse |
| ev_seq_err | input | 2 | Per-bank invalid command sequence pulse |
| ev_psusp | input | 2 | Per-bank program suspended pulse |
| ev_esusp | input | 2 | Per-bank erase suspended pulse |
| ev_resume | input | 2 | Per-bank resume pulse |
| clr_req | input | 2 | Per-bank clear-status pulse |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request accepted when high |
| rd_addr | input | ADDR_W | Word address of the read |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response when high |
| rsp_data | output | DATA_W | Status in the low byte, upper byte zero |

## Verification
The bench builds the block with ADDR_W = 12, BANK_A_WORDS = 512 and top placement. With these values the bank split falls at 0xE00. The words on both sides of the split, and the very top word, can then be read in a few cycles. With the 16-bit data width, the zero upper byte is visible on every response. Holding the response under back-pressure while one bank's engine goes busy and raises a new failure shows that a captured word is independent of later register updates.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
  localparam int NUM_BANKS = 2;
  localparam int SR_W      = 8;

  localparam int SR_READY  = 7;
  localparam int SR_ESUSP  = 6;
  localparam int SR_EERR   = 5;
  localparam int SR_PERR   = 4;
  localparam int SR_VERR   = 3;
  localparam int SR_PSUSP  = 2;
  localparam int SR_LERR   = 1;

  localparam logic [SR_W-1:0] ERR_MASK =
    SR_W'((1 << SR_EERR) | (1 << SR_PERR) | (1 << SR_VERR) | (1 << SR_LERR));

  typedef struct packed {
    logic esusp;
    logic eerr;
    logic perr;
    logic verr;
    logic psusp;
    logic lerr;
  } sticky_t;

  function automatic logic [SR_W-1:0] pack_status(input logic busy, input sticky_t s);
    logic [SR_W-1:0] w;
    w           = '0;
    w[SR_READY] = ~(busy & ~(s.psusp | s.esusp));
    w[SR_ESUSP] = s.esusp;
    w[SR_EERR]  = s.eerr;
    w[SR_PERR]  = s.perr;
    w[SR_VERR]  = s.verr;
    w[SR_PSUSP] = s.psusp;
    w[SR_LERR]  = s.lerr;
    return w;
  endfunction
endpackage

// File: rtl/dbs_bank.sv
module dbs_bank
  import dbs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            busy,
  input  logic            set_perr,
  input  logic            set_eerr,
  input  logic            set_verr,
  input  logic            set_lerr,
  input  logic            set_seq,
  input  logic            set_psusp,
  input  logic            set_esusp,
  input  logic            resume,
  input  logic            clr,
  output logic [SR_W-1:0] sts
);
  sticky_t cur_q, nxt;

  // clear first, then sets, so a same-cycle event survives the clear
  always_comb begin
    nxt = cur_q;
    if (clr) begin
      nxt.perr = 1'b0;
      nxt.eerr = 1'b0;
      nxt.verr = 1'b0;
      nxt.lerr = 1'b0;
    end
    if (set_perr | set_seq) nxt.perr = 1'b1;
    if (set_eerr | set_seq) nxt.eerr = 1'b1;
    if (set_verr)           nxt.verr = 1'b1;
    if (set_lerr)           nxt.lerr = 1'b1;
    if (resume) begin
      nxt.psusp = 1'b0;
      nxt.esusp = 1'b0;
    end
    if (set_psusp) nxt.psusp = 1'b1;
    if (set_esusp) nxt.esusp = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign sts = pack_status(busy, cur_q);
endmodule

// File: rtl/dbs_bank_sel.sv
module dbs_bank_sel #(
  parameter int ADDR_W       = 21,
  parameter int BANK_A_WORDS = 262144,
  parameter bit TOP_BOOT     = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              bank_idx
);
  generate
    if (TOP_BOOT) begin : g_top
      localparam logic [ADDR_W-1:0] A_LO = ADDR_W'((2 ** ADDR_W) - BANK_A_WORDS);
      assign bank_idx = (addr >= A_LO) ? 1'b0 : 1'b1;
    end else begin : g_bottom
      localparam logic [ADDR_W-1:0] A_END = ADDR_W'(BANK_A_WORDS);
      assign bank_idx = (addr < A_END) ? 1'b0 : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dbs_read_port.sv
module dbs_read_port
  import dbs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           rd_valid,
  output logic                           rd_ready,
  input  logic                           rd_bank,
  input  logic [NUM_BANKS-1:0][SR_W-1:0] bank_sts,
  output logic                           rsp_valid,
  input  logic                           rsp_ready,
  output logic [DATA_W-1:0]              rsp_data
);
  localparam int PAD_W = DATA_W - SR_W;

  logic accept;

  assign rd_ready = ~rsp_valid | rsp_ready;
  assign accept   = rd_valid & rd_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_data  <= {{PAD_W{1'b0}}, bank_sts[rd_bank]};
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_bank_status.sv
module dual_bank_status
  import dbs_pkg::*;
#(
  parameter int ADDR_W       = 21,
  parameter int BANK_A_WORDS = 262144,
  parameter bit TOP_BOOT     = 1'b0,
  parameter int DATA_W       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_BANKS-1:0] eng_busy,
  input  logic [NUM_BANKS-1:0] ev_prog_fail,
  input  logic [NUM_BANKS-1:0] ev_erase_fail,
  input  logic [NUM_BANKS-1:0] ev_vpp_low,
  input  logic [NUM_BANKS-1:0] ev_lock_hit,
  input  logic [NUM_BANKS-1:0] ev_seq_err,
  input  logic [NUM_BANKS-1:0] ev_psusp,
  input  logic [NUM_BANKS-1:0] ev_esusp,
  input  logic [NUM_BANKS-1:0] ev_resume,
  input  logic [NUM_BANKS-1:0] clr_req,
  input  logic                 rd_valid,
  output logic                 rd_ready,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rsp_valid,
  input  logic                 rsp_ready,
  output logic [DATA_W-1:0]    rsp_data
);
  logic [NUM_BANKS-1:0][SR_W-1:0] bank_sts;
  logic                           sel_bank;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      dbs_bank u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (eng_busy[b]),
        .set_perr  (ev_prog_fail[b]),
        .set_eerr  (ev_erase_fail[b]),
        .set_verr  (ev_vpp_low[b]),
        .set_lerr  (ev_lock_hit[b]),
        .set_seq   (ev_seq_err[b]),
        .set_psusp (ev_psusp[b]),
        .set_esusp (ev_esusp[b]),
        .resume    (ev_resume[b]),
        .clr       (clr_req[b]),
        .sts       (bank_sts[b])
      );
    end
  endgenerate

  dbs_bank_sel #(
    .ADDR_W       (ADDR_W),
    .BANK_A_WORDS (BANK_A_WORDS),
    .TOP_BOOT     (TOP_BOOT)
  ) u_sel (
    .addr     (rd_addr),
    .bank_idx (sel_bank)
  );

  dbs_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_bank   (sel_bank),
    .bank_sts  (bank_sts),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker
  import dbs_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_BANKS-1:0]           ev_prog_fail,
  input logic [NUM_BANKS-1:0]           ev_erase_fail,
  input logic [NUM_BANKS-1:0]           ev_vpp_low,
  input logic [NUM_BANKS-1:0]           ev_lock_hit,
  input logic [NUM_BANKS-1:0]           ev_seq_err,
  input logic [NUM_BANKS-1:0]           clr_req,
  input logic                           rd_ready,
  input logic                           rsp_valid,
  input logic                           rsp_ready,
  input logic [DATA_W-1:0]              rsp_data,
  input logic [NUM_BANKS-1:0][SR_W-1:0] bank_sts
);
  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
      assert_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req[b] |=> (((($past(bank_sts[b]) & ERR_MASK) & ~bank_sts[b])) == '0));

      assert_seq_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev_seq_err[b] |=> (bank_sts[b][SR_PERR] && bank_sts[b][SR_EERR]));

      assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req[b] && !ev_prog_fail[b] && !ev_erase_fail[b] && !ev_vpp_low[b]
         && !ev_lock_hit[b] && !ev_seq_err[b]) |=> ((bank_sts[b] & ERR_MASK) == '0));

      assert_susp_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sts[b][SR_PSUSP] || bank_sts[b][SR_ESUSP]) |-> bank_sts[b][SR_READY]);
    end
  endgenerate

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_backpressure_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready);
endmodule

bind dual_bank_status dbs_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .ev_prog_fail  (ev_prog_fail),
  .ev_erase_fail (ev_erase_fail),
  .ev_vpp_low    (ev_vpp_low),
  .ev_lock_hit   (ev_lock_hit),
  .ev_seq_err    (ev_seq_err),
  .clr_req       (clr_req),
  .rd_ready      (rd_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .bank_sts      (bank_sts)
);

// File: tb/dual_bank_status_tb.sv
module dual_bank_status_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] eng_busy = '0, ev_prog_fail = '0, ev_erase_fail = '0, ev_vpp_low = '0;
  logic [1:0] ev_lock_hit = '0, ev_seq_err = '0, ev_psusp = '0, ev_esusp = '0;
  logic [1:0] ev_resume = '0, clr_req = '0;
  logic rd_valid = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic rd_ready, rsp_valid;
  logic [15:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_status #(.ADDR_W(AW), .BANK_A_WORDS(512), .TOP_BOOT(1'b1), .DATA_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .eng_busy(eng_busy), .ev_prog_fail(ev_prog_fail),
    .ev_erase_fail(ev_erase_fail), .ev_vpp_low(ev_vpp_low), .ev_lock_hit(ev_lock_hit),
    .ev_seq_err(ev_seq_err), .ev_psusp(ev_psusp), .ev_esusp(ev_esusp),
    .ev_resume(ev_resume), .clr_req(clr_req), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  typedef struct {
    logic [15:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // bench model of the sticky state, built from the requirements
  logic [1:0] m_pe = '0, m_ee = '0, m_ve = '0, m_le = '0, m_ps = '0, m_es = '0;

  function automatic logic [7:0] model_sts(input int b);
    logic [7:0] w;
    w    = '0;
    w[7] = ~(eng_busy[b] & ~(m_ps[b] | m_es[b]));
    w[6] = m_es[b];
    w[5] = m_ee[b];
    w[4] = m_pe[b];
    w[3] = m_ve[b];
    w[2] = m_ps[b];
    w[1] = m_le[b];
    return w;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // hold the currently driven pulses for one edge, update the model, drop them
  task automatic tick_events();
    @(posedge clk);
    #1;
    for (int b = 0; b < 2; b++) begin
      if (clr_req[b]) begin
        m_pe[b] = 1'b0; m_ee[b] = 1'b0; m_ve[b] = 1'b0; m_le[b] = 1'b0;
      end
      if (ev_prog_fail[b] | ev_seq_err[b])  m_pe[b] = 1'b1;
      if (ev_erase_fail[b] | ev_seq_err[b]) m_ee[b] = 1'b1;
      if (ev_vpp_low[b])  m_ve[b] = 1'b1;
      if (ev_lock_hit[b]) m_le[b] = 1'b1;
      if (ev_resume[b]) begin m_ps[b] = 1'b0; m_es[b] = 1'b0; end
      if (ev_psusp[b]) m_ps[b] = 1'b1;
      if (ev_esusp[b]) m_es[b] = 1'b1;
    end
    ev_prog_fail = '0; ev_erase_fail = '0; ev_vpp_low = '0; ev_lock_hit = '0;
    ev_seq_err = '0; ev_psusp = '0; ev_esusp = '0; ev_resume = '0; clr_req = '0;
  endtask

  // called just after a rising edge; the bank index follows the split at 0xE00
  task automatic do_read(input logic [AW-1:0] a, input string tag);
    exp_t e;
    int b;
    b = (a >= 12'hE00) ? 0 : 1;
    e.val = {8'h00, model_sts(b)};
    e.tag = tag;
    sb_q.push_back(e);
    rd_addr  = a;
    rd_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (rd_ready) break;
    end
    @(posedge clk);
    #1;
    rd_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  // monitor: pops the scoreboard on each response handshake
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (sb_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R10: unexpected response actual=%h expected=none", rsp_data);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rsp_data, e.val);
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rsp_valid after reset", {15'b0, rsp_valid}, 16'h0000);
    check("R11 rd_ready after reset", {15'b0, rd_ready}, 16'h0001);
    @(posedge clk); #1;
    do_read(12'hE00, "R1 bank a reset value");
    do_read(12'h000, "R1 bank b reset value");

    // R2: busy clears ready on bank b only
    eng_busy[1] = 1'b1;
    do_read(12'h000, "R2 busy bank b");
    do_read(12'hE00, "R2 idle bank a");

    // R3: program failure sticks after engine goes idle
    ev_prog_fail[1] = 1'b1;
    tick_events();
    eng_busy[1] = 1'b0;
    do_read(12'h000, "R3 program failure set");
    repeat (4) @(posedge clk);
    #1;
    do_read(12'h123, "R3 program failure held");
    ev_lock_hit[0] = 1'b1; ev_vpp_low[0] = 1'b1;
    tick_events();
    do_read(12'hE00, "R3 lock and supply failures bank a");

    // R4: invalid sequence sets both failure bits
    ev_seq_err[1] = 1'b1;
    tick_events();
    do_read(12'h000, "R4 sequence error bank b");
    do_read(12'hE00, "R4 bank a untouched");

    // R5: clear bank b only
    clr_req[1] = 1'b1;
    tick_events();
    do_read(12'h000, "R5 bank b cleared");
    do_read(12'hE00, "R5 bank a kept");

    // R7: suspend while busy
    eng_busy[0] = 1'b1; ev_esusp[0] = 1'b1;
    tick_events();
    do_read(12'hE00, "R7 erase suspended reads ready");
    clr_req[0] = 1'b1;
    tick_events();
    do_read(12'hE00, "R5 clear keeps suspend bit");
    ev_resume[0] = 1'b1;
    tick_events();
    do_read(12'hE00, "R7 resume clears suspend");
    ev_psusp[0] = 1'b1;
    tick_events();
    do_read(12'hE00, "R7 program suspended");
    ev_resume[0] = 1'b1;
    tick_events();
    eng_busy[0] = 1'b0;
    do_read(12'hE00, "R7 idle after resume");

    // R6: same-cycle set and clear
    ev_erase_fail[1] = 1'b1; clr_req[1] = 1'b1;
    tick_events();
    do_read(12'h000, "R6 set wins over clear");

    // R8: split boundaries
    do_read(12'hDFF, "R8 last bank b word");
    do_read(12'hFFF, "R8 top word bank a");

    // R9 + R10 + R11: stall response while state changes
    rsp_ready = 1'b0;
    do_read(12'h000, "R10 captured value released");
    eng_busy[1] = 1'b1; ev_vpp_low[1] = 1'b1;
    tick_events();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R10 response held stable", rsp_data, 16'h00A0);
      check("R11 request blocked under stall", {15'b0, rd_ready}, 16'h0000);
      check("R9 upper byte zero", {8'h00, rsp_data[15:8]}, 16'h0000);
    end
    @(posedge clk); #1;
    rsp_ready = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    check("R11 rsp_valid falls after handshake", {15'b0, rsp_valid}, 16'h0000);
    @(posedge clk); #1;
    do_read(12'h000, "R10 new read sees new state");

    repeat (2) @(posedge clk);
    if (sb_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R10: pending responses actual=%0d expected=0", sb_q.size());
    end
    summary();
  end
endmodule